// File: doc/BRIEF.md
# Condition-Register Fail-First Sequencer

This block walks the elements of a vectorised condition-register operation in order, from element 0 up to the requested vector length minus one. The operation itself runs elsewhere. It hands each element's own condition result to the sequencer over a valid/ready result stream. The result is either a 4-bit field or a single bit in bit 0. For each element the sequencer picks one bit of that result and compares it with an invert flag. A match lets the element's result be written. The first mismatch ends the vector early and yields a shortened length.

A run begins with a `start` pulse while the block is idle. On that pulse the block takes the vector length, the 2-bit mode-select code, the operand-width flag, the 2-bit selector, the invert flag and the keep-failing-element flag. Only mode-select code `01` starts a run. The other codes, including the reserved `10`, are ignored. The result stream follows standard valid/ready rules. An element is consumed only in a cycle where `res_valid` and `res_ready` are both high. The producer may hold `res_valid` low for any number of cycles, and the sequencer then waits without advancing. `res_ready` is high only while a run is active. At most one element is consumed per clock.

In single-bit (5-bit operand) mode, the two selector bits are not needed for bit selection. They are instead passed out as a zeroing flag and an Rc1 flag for downstream logic.

Top module: `cr_failfirst_seq`

## Requirements
- R1: A `start` pulse while idle begins a run only when `mode_sel` is 2'b01. With 2'b00, 2'b10 or 2'b11 the pulse is ignored: `busy` and `done` stay low and `vl_out` keeps its value.
- R2: An accepted start with `vl_in` = 0 raises `done` in the next cycle with `vl_out` = 0, and no write-enable is produced.
- R3: In single-bit mode (`wide_op` = 1), the tested bit is `res_field[0]`.
- R4: In field mode (`wide_op` = 0), the tested bit is `res_field[sel]`, where `sel` is the 2-bit selector taken as an unsigned index 0..3.
- R5: An element passes when its tested bit equals `inv`. A passing element raises `wr_en` in its handshake cycle, with `wr_idx` equal to the element index, counting up from 0.
- R6: On the first failing element i with `keep_fail` = 1, `wr_en` is raised for element i, the run stops and `vl_out` becomes i+1.
- R7: On the first failing element i with `keep_fail` = 0, `wr_en` stays low for element i, the run stops and `vl_out` becomes i.
- R8: If every element passes, every index 0..VL-1 is written once in order and `vl_out` equals the requested VL.
- R9: `done` is a one-cycle pulse in the cycle after the final handshake. `busy` is low in that cycle, and `vl_out` holds until the next run ends.
- R10: `res_ready` is high exactly while `busy` is high. A cycle without a handshake produces no `wr_en` and leaves `wr_idx` unchanged.
- R11: `zero_flag` equals `sel[1]` and `rc1_flag` equals `sel[0]` latched at start when `wide_op` was 1. Both are 0 after a field-mode start.
- R12: After reset, `busy`, `done`, `wr_en`, `vl_out`, `zero_flag` and `rc1_flag` are all 0.
- R13: A `start` pulse during an active run is ignored, and the run completes as if the pulse had not occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, sampled when idle |
| mode_sel | input | 2 | Mode-select code; 2'b01 selects fail-first |
| vl_in | input | VL_W | Requested vector length |
| wide_op | input | 1 | 1 = single-bit result, 0 = 4-bit field result |
| sel | input | 2 | Bit selector (field mode) or zero/Rc1 flags (single-bit mode) |
| inv | input | 1 | Value the tested bit must equal to pass |
| keep_fail | input | 1 | 1 = write the failing element and count it in the new length |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready |
| res_field | input | 4 | Element result; bit 0 only in single-bit mode |
| wr_en | output | 1 | Write enable for the current element |
| wr_idx | output | VL_W | Index of the element being written |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | VL_W | Resulting vector length |
| zero_flag | output | 1 | Zeroing flag from single-bit mode |
| rc1_flag | output | 1 | Rc1 flag from single-bit mode |

## Verification
The bench builds the block with `MAX_VL` = 20, which makes `vl_in` 5 bits wide. This keeps runs short enough that the largest lengths, and failures at the last element, occur often under random stimulus. At that width the element counter can reach the final index of a run of length 20 and still compute i+1 for a kept failure. Random gaps in `res_valid` exercise back-pressure at every index. Directed runs cover a zero length, an immediate failure at element 0 under both settings of the keep flag, and all three codes that must not start a run.

// File: rtl/cr_ff_pkg.sv
package cr_ff_pkg;
  localparam int FIELD_W = 4;
  localparam int SEL_W   = $clog2(FIELD_W);
  localparam logic [1:0] FAILFIRST_CODE = 2'b01;

  typedef enum logic {S_IDLE, S_RUN} seq_state_t;

  typedef struct packed {
    logic             wide;
    logic [SEL_W-1:0] sel;
    logic             inv;
    logic             keep;
  } ff_cfg_t;
endpackage

// File: rtl/cr_ff_cfg.sv
module cr_ff_cfg
  import cr_ff_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             wide_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             inv_in,
  input  logic             keep_in,
  output ff_cfg_t          cfg,
  output logic             zero_flag,
  output logic             rc1_flag
);
  ff_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q.wide <= wide_in;
      cfg_q.sel  <= sel_in;
      cfg_q.inv  <= inv_in;
      cfg_q.keep <= keep_in;
    end
  end

  assign cfg       = cfg_q;
  assign zero_flag = cfg_q.wide & cfg_q.sel[1];
  assign rc1_flag  = cfg_q.wide & cfg_q.sel[0];
endmodule

// File: rtl/cr_ff_test.sv
module cr_ff_test
  import cr_ff_pkg::*;
(
  input  ff_cfg_t            cfg,
  input  logic [FIELD_W-1:0] res_field,
  output logic               pass
);
  logic [FIELD_W-1:0] hit;
  logic               picked;

  for (genvar g = 0; g < FIELD_W; g++) begin : g_pick
    assign hit[g] = res_field[g] & (cfg.sel == SEL_W'(g));
  end

  assign picked = cfg.wide ? res_field[0] : |hit;
  assign pass   = (picked == cfg.inv);
endmodule

// File: rtl/cr_ff_ctrl.sv
module cr_ff_ctrl
  import cr_ff_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            mode_ok,
  input  logic [VL_W-1:0] vl_in,
  input  logic            keep,
  input  logic            pass,
  input  logic            res_valid,
  output logic            res_ready,
  output logic            accept,
  output logic            wr_en,
  output logic [VL_W-1:0] wr_idx,
  output logic            busy,
  output logic            done,
  output logic [VL_W-1:0] vl_out
);
  seq_state_t      state;
  logic [VL_W-1:0] idx;
  logic [VL_W-1:0] vl_q;
  logic [VL_W-1:0] vl_res;
  logic            done_q;
  logic            hs;
  logic            last;

  assign accept    = start & mode_ok & (state == S_IDLE);
  assign res_ready = (state == S_RUN);
  assign hs        = res_valid & res_ready;
  assign last      = ((idx + VL_W'(1)) == vl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      idx    <= '0;
      vl_q   <= '0;
      vl_res <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            if (vl_in == '0) begin
              vl_res <= '0;
              done_q <= 1'b1;
            end else begin
              state <= S_RUN;
              idx   <= '0;
              vl_q  <= vl_in;
            end
          end
        end
        S_RUN: begin
          if (hs) begin
            if (!pass) begin
              vl_res <= keep ? idx + VL_W'(1) : idx;
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else if (last) begin
              vl_res <= vl_q;
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              idx <= idx + VL_W'(1);
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign wr_en  = hs & (pass | keep);
  assign wr_idx = idx;
  assign busy   = (state == S_RUN);
  assign done   = done_q;
  assign vl_out = vl_res;
endmodule

// File: rtl/cr_failfirst_seq.sv
module cr_failfirst_seq
  import cr_ff_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         mode_sel,
  input  logic [VL_W-1:0]    vl_in,
  input  logic               wide_op,
  input  logic [1:0]         sel,
  input  logic               inv,
  input  logic               keep_fail,
  input  logic               res_valid,
  output logic               res_ready,
  input  logic [3:0]         res_field,
  output logic               wr_en,
  output logic [VL_W-1:0]    wr_idx,
  output logic               busy,
  output logic               done,
  output logic [VL_W-1:0]    vl_out,
  output logic               zero_flag,
  output logic               rc1_flag
);
  ff_cfg_t cfg;
  logic    accept;
  logic    pass;
  logic    mode_ok;

  assign mode_ok = (mode_sel == FAILFIRST_CODE);

  cr_ff_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .wide_in   (wide_op),
    .sel_in    (sel),
    .inv_in    (inv),
    .keep_in   (keep_fail),
    .cfg       (cfg),
    .zero_flag (zero_flag),
    .rc1_flag  (rc1_flag)
  );

  cr_ff_test u_test (
    .cfg       (cfg),
    .res_field (res_field),
    .pass      (pass)
  );

  cr_ff_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_ok   (mode_ok),
    .vl_in     (vl_in),
    .keep      (cfg.keep),
    .pass      (pass),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .accept    (accept),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .busy      (busy),
    .done      (done),
    .vl_out    (vl_out)
  );
endmodule

// File: rtl/cr_ff_checker.sv
module cr_ff_checker #(
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [1:0]      mode_sel,
  input logic [VL_W-1:0] vl_in,
  input logic            res_valid,
  input logic            res_ready,
  input logic            wr_en,
  input logic [VL_W-1:0] wr_idx,
  input logic            busy,
  input logic            done,
  input logic [VL_W-1:0] vl_out
);
  logic [VL_W-1:0] cap_vl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_vl <= '0;
    else if (start && !busy && mode_sel == 2'b01) cap_vl <= vl_in;
  end

  // R1
  a_r1_other_codes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode_sel != 2'b01) |=> (!busy && !done));

  // R2
  a_r2_zero_length: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode_sel == 2'b01 && vl_in == '0) |=> (done && vl_out == '0 && !busy));

  // R5
  a_r5_write_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (res_valid && res_ready));

  // R8
  a_r8_length_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vl_out <= cap_vl));

  // R9
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !wr_en));

  // R10
  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(res_valid && res_ready)) |=> (busy && $stable(wr_idx)));
endmodule

bind cr_failfirst_seq cr_ff_checker #(.VL_W(VL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mode_sel  (mode_sel),
  .vl_in     (vl_in),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .busy      (busy),
  .done      (done),
  .vl_out    (vl_out)
);

// File: tb/tb_cr_failfirst_seq.sv
module tb_cr_failfirst_seq;
  localparam int MAX_VL = 20;
  localparam int VL_W   = $clog2(MAX_VL + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [1:0]      mode_sel = 2'b00;
  logic [VL_W-1:0] vl_in = '0;
  logic            wide_op = 1'b0;
  logic [1:0]      sel = 2'b00;
  logic            inv = 1'b0;
  logic            keep_fail = 1'b0;
  logic            res_valid = 1'b0;
  logic            res_ready;
  logic [3:0]      res_field = 4'h0;
  logic            wr_en;
  logic [VL_W-1:0] wr_idx;
  logic            busy;
  logic            done;
  logic [VL_W-1:0] vl_out;
  logic            zero_flag;
  logic            rc1_flag;

  int total = 0;
  int bad = 0;
  int last_vl = 0;

  always #5 clk = ~clk;

  cr_failfirst_seq #(.MAX_VL(MAX_VL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel), .vl_in(vl_in),
    .wide_op(wide_op), .sel(sel), .inv(inv), .keep_fail(keep_fail),
    .res_valid(res_valid), .res_ready(res_ready), .res_field(res_field),
    .wr_en(wr_en), .wr_idx(wr_idx), .busy(busy), .done(done), .vl_out(vl_out),
    .zero_flag(zero_flag), .rc1_flag(rc1_flag)
  );

  function automatic bit tested_bit(logic [3:0] f, bit w, logic [1:0] s);
    return w ? f[0] : f[s];
  endfunction

  task automatic check(int act, int exp, string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One fail-first run; pass_pct sets the chance each element passes.
  task automatic run_op(int vl, bit w, logic [1:0] s, bit iv, bit kp, int pass_pct, bit poke);
    int exp_vl;
    bit poked;
    exp_vl = vl;
    poked = 1'b0;
    @(negedge clk);
    start = 1'b1; mode_sel = 2'b01; vl_in = VL_W'(vl);
    wide_op = w; sel = s; inv = iv; keep_fail = kp;
    @(negedge clk);
    start = 1'b0; mode_sel = 2'($urandom); vl_in = VL_W'($urandom);
    wide_op = 1'($urandom); sel = 2'($urandom); inv = 1'($urandom); keep_fail = 1'($urandom);
    check(zero_flag, w & s[1], "R11 zero_flag");
    check(rc1_flag, w & s[0], "R11 rc1_flag");
    if (vl == 0) begin
      check(done, 1, "R2 done on zero length");
      check(vl_out, 0, "R2 vl_out zero");
      check(wr_en, 0, "R2 no write");
      @(negedge clk);
      check(done, 0, "R9 done one cycle");
      last_vl = 0;
      return;
    end
    check(busy, 1, "R1 busy after start");
    for (int i = 0; i < vl; i++) begin
      logic [3:0] f;
      bit want;
      if ($urandom % 3 == 0) begin
        res_valid = 1'b0;
        res_field = 4'($urandom);
        if (poke && !poked) begin
          start = 1'b1; mode_sel = 2'b01; vl_in = '0;
          poked = 1'b1;
        end
        #1;
        check(res_ready, 1, "R10 ready while busy");
        check(wr_en, 0, "R10 no write without valid");
        @(negedge clk);
        start = 1'b0;
        check(wr_idx, i, "R10 index held in stall");
        check(busy, 1, "R13 start ignored while busy");
      end
      f = 4'($urandom);
      want = (($urandom % 100) < pass_pct);
      if ((tested_bit(f, w, s) == iv) != want) begin
        if (w) f[0] = ~f[0];
        else   f[s] = ~f[s];
      end
      res_field = f;
      res_valid = 1'b1;
      #1;
      if (w) check(wr_en, (f[0] == iv) || kp, "R3 single-bit test");
      else   check(wr_en, (f[s] == iv) || kp, "R4 field bit test");
      if (want) begin
        check(wr_idx, i, "R5 pass index");
      end else if (kp) begin
        check(wr_idx, i, "R6 kept failing index");
      end
      @(negedge clk);
      res_valid = 1'b0;
      if (!want) begin
        exp_vl = kp ? i + 1 : i;
        break;
      end
    end
    check(done, 1, "R9 done after final element");
    check(busy, 0, "R9 idle at done");
    if (exp_vl == vl) check(vl_out, exp_vl, "R8 full length kept");
    else if (kp)      check(vl_out, exp_vl, "R6 truncated to i+1");
    else              check(vl_out, exp_vl, "R7 truncated to i");
    @(negedge clk);
    check(done, 0, "R9 done one cycle");
    check(vl_out, exp_vl, "R9 vl_out holds");
    last_vl = exp_vl;
  endtask

  task automatic try_ignored(logic [1:0] code);
    @(negedge clk);
    start = 1'b1; mode_sel = code; vl_in = VL_W'(5);
    @(negedge clk);
    start = 1'b0;
    check(busy, 0, "R1 code ignored busy");
    check(done, 0, "R1 code ignored done");
    @(negedge clk);
    check(done, 0, "R1 code ignored done later");
    check(vl_out, last_vl, "R1 code ignored vl_out");
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(busy, 0, "R12 reset busy");
    check(done, 0, "R12 reset done");
    check(vl_out, 0, "R12 reset vl_out");
    check(zero_flag | rc1_flag, 0, "R12 reset flags");
    check(wr_en, 0, "R12 reset wr_en");
    rst_n = 1'b1;
    @(negedge clk);
    run_op(MAX_VL, 1'b0, 2'd2, 1'b1, 1'b0, 100, 1'b0);
    try_ignored(2'b10);
    try_ignored(2'b00);
    try_ignored(2'b11);
    run_op(0, 1'b1, 2'd3, 1'b0, 1'b1, 100, 1'b0);
    run_op(6, 1'b0, 2'd0, 1'b0, 1'b0, 0, 1'b0);
    run_op(6, 1'b1, 2'd1, 1'b1, 1'b1, 0, 1'b0);
    run_op(1, 1'b1, 2'd2, 1'b0, 1'b0, 100, 1'b0);
    run_op(MAX_VL, 1'b1, 2'd3, 1'b0, 1'b1, 100, 1'b1);
    for (int k = 0; k < 60; k++) begin
      run_op(int'($urandom % (MAX_VL + 1)), 1'($urandom), 2'($urandom), 1'($urandom),
             1'($urandom), 80 + int'($urandom % 21), 1'($urandom));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule